// File: doc/BRIEF.md
# Truncated Message Merge Unit

This block builds one outgoing variable-to-check message for a non-binary LDPC decoder. Two candidate streams arrive, each carrying (reliability, field symbol) pairs. Stream A holds check-to-variable entries that are already cost-corrected and sorted in increasing reliability. Stream B holds intrinsic candidates in increasing reliability. The block raises each B reliability by a per-message base, which is the largest check-to-variable reliability plus a fixed offset. It then emits the `NM` smallest pairs in non-decreasing order. A lower reliability value means a more likely symbol.

Symbols of the check-to-variable message are announced on a plain marking port. Each mark sets one bit in a flag bitmap that has one bit per field element. An intrinsic candidate whose symbol is flagged is a duplicate: it is dropped and the next B candidate is fetched. The bitmap has two banks. The next message can be marked while the current one is merged, and a bank is wiped as soon as its message has produced its last output.

All three streams use valid/ready. A pair moves when valid and ready are both high at a rising edge. A source must hold its valid and payload until the pair is taken. This block's ready signals never stall a source whose data is not needed. The output holds its pair while `o_ready` is low. The intrinsic source restarts its list at each accepted message start. Entries of B that are left unread at the end of a message are not drained.

Top module: `v2c_merge`

## Requirements
- R1: After reset, `o_valid`, `a_ready` and `b_ready` are low, both flag banks are clear, and the block waits for `msg_start`.
- R2: A B candidate at the head whose symbol was marked for the current message is consumed (`b_ready` high) without producing an output, and the next B candidate takes its place.
- R3: A B candidate competes with reliability sat(`b_llr` + sat(`tail_llr` + OFFSET)), where `tail_llr` is captured in the cycle `msg_start` is accepted.
- R4: Each output is the smaller of the A head and the adjusted B head. On equal reliability the A entry is emitted.
- R5: Exactly `NM` pairs are emitted per message, in non-decreasing reliability order. `o_last` is high on the `NM`-th pair only.
- R6: Each output handshake takes exactly one element, and only from the stream that supplied it. No other element is consumed, apart from duplicates (R2) and the drain (R11).
- R7: While `o_valid` is high and `o_ready` is low, neither A nor B is consumed.
- R8: Marks arriving while a message is merged go to the other bank and do not change which B candidates of the current message are dropped.
- R9: The bank used by a message is cleared after its final output, so its marks never drop candidates of a later message.
- R10: `msg_start` is ignored unless the block is idle. The merge in progress, its base and its bank are unaffected.
- R11: After the `NM`-th output, the block accepts and discards the remaining A entries until `NM` A entries of the message have been taken. No further output is produced.
- R12: Every reliability sum saturates at 2^LLR_W-1, which is 255 with the default width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| msg_start | input | 1 | Pulse to begin merging the message last marked (idle only) |
| tail_llr | input | LLR_W | Largest check-to-variable reliability of that message |
| mark_valid | input | 1 | Mark one symbol of the next message |
| mark_sym | input | SYM_W | Symbol to mark |
| a_valid | input | 1 | Corrected check-to-variable entry valid |
| a_ready | output | 1 | Entry taken |
| a_llr | input | LLR_W | Entry reliability |
| a_sym | input | SYM_W | Entry symbol |
| b_valid | input | 1 | Intrinsic candidate valid |
| b_ready | output | 1 | Candidate taken (emitted or dropped) |
| b_llr | input | LLR_W | Candidate raw reliability |
| b_sym | input | SYM_W | Candidate symbol |
| o_valid | output | 1 | Output pair valid |
| o_ready | input | 1 | Downstream accepts pair |
| o_llr | output | LLR_W | Output reliability |
| o_sym | output | SYM_W | Output symbol |
| o_last | output | 1 | Final pair of the message |

## Verification
The bench runs a sweep of 48 messages. Their A slopes, A start values, B slopes and tails are derived arithmetically, and an independent merge model predicts every pair and the exact number of B candidates consumed. Zero slopes produce runs of ties that separate A-first from B-first arbitration. Low tails interleave the two streams, while a tail near full scale saturates every B candidate, which separates saturation from wrap-around. Shifted symbol sets from one message to the next expose a missing bank clear or a wrong bank choice. A periodic `o_ready` stall pattern and a busy-time `msg_start` show up as lost, repeated or reordered pairs.

// File: rtl/v2c_pkg.sv
package v2c_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_MERGE = 2'd1,
    ST_DRAIN = 2'd2
  } v2c_state_e;
endpackage

// File: rtl/v2c_sat_add.sv
module v2c_sat_add #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  logic [W:0] sum;
  always_comb begin
    sum = {1'b0, a} + {1'b0, b};
    y   = sum[W] ? {W{1'b1}} : sum[W-1:0];
  end
endmodule

// File: rtl/v2c_flag_store.sv
module v2c_flag_store #(
  parameter int SYM_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_bank,
  input  logic [SYM_W-1:0] wr_sym,
  input  logic             clr_en,
  input  logic             clr_bank,
  input  logic             rd_bank,
  input  logic [SYM_W-1:0] rd_sym,
  output logic             rd_flag
);
  localparam int Q = 1 << SYM_W;

  logic [Q-1:0] bank_vec [2];

  for (genvar g = 0; g < 2; g++) begin : g_bank
    logic [Q-1:0] bits_q, bits_d;
    always_comb begin
      bits_d = bits_q;
      if (clr_en && (clr_bank == 1'(g))) bits_d = '0;
      if (wr_en && (wr_bank == 1'(g)))   bits_d[wr_sym] = 1'b1;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bits_q <= '0;
      else        bits_q <= bits_d;
    end
    assign bank_vec[g] = bits_q;
  end

  assign rd_flag = rd_bank ? bank_vec[1][rd_sym] : bank_vec[0][rd_sym];

  // R8: marking and clearing never target the same bank in one cycle
  p_bank_sep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && clr_en) |-> (wr_bank != clr_bank));
endmodule

// File: rtl/v2c_min_select.sv
module v2c_min_select #(
  parameter int LLR_W = 8,
  parameter int SYM_W = 6
) (
  input  logic [LLR_W-1:0] a_llr,
  input  logic [SYM_W-1:0] a_sym,
  input  logic [LLR_W-1:0] b_llr,
  input  logic [SYM_W-1:0] b_sym,
  output logic             pick_a,
  output logic [LLR_W-1:0] y_llr,
  output logic [SYM_W-1:0] y_sym
);
  always_comb begin
    pick_a = (a_llr <= b_llr);
    y_llr  = pick_a ? a_llr : b_llr;
    y_sym  = pick_a ? a_sym : b_sym;
  end
endmodule

// File: rtl/v2c_merge.sv
module v2c_merge
  import v2c_pkg::*;
#(
  parameter int SYM_W  = 6,
  parameter int LLR_W  = 8,
  parameter int NM     = 12,
  parameter int OFFSET = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             msg_start,
  input  logic [LLR_W-1:0] tail_llr,
  input  logic             mark_valid,
  input  logic [SYM_W-1:0] mark_sym,
  input  logic             a_valid,
  output logic             a_ready,
  input  logic [LLR_W-1:0] a_llr,
  input  logic [SYM_W-1:0] a_sym,
  input  logic             b_valid,
  output logic             b_ready,
  input  logic [LLR_W-1:0] b_llr,
  input  logic [SYM_W-1:0] b_sym,
  output logic             o_valid,
  input  logic             o_ready,
  output logic [LLR_W-1:0] o_llr,
  output logic [SYM_W-1:0] o_sym,
  output logic             o_last
);
  localparam int               CNT_W    = $clog2(NM + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(NM - 1);
  localparam logic [LLR_W-1:0] OFS      = LLR_W'(OFFSET);

  v2c_state_e       state_q;
  logic             wr_bank_q, rd_bank_q;
  logic [LLR_W-1:0] base_q, base_d, b_adj;
  logic [CNT_W-1:0] out_cnt_q, a_cnt_q;
  logic [LLR_W-1:0] prev_llr_q;
  logic             have_prev_q;
  logic             merging, draining, dup, pick_a, fire, last_fire, a_take;

  v2c_sat_add #(.W(LLR_W)) u_base_add (.a(tail_llr), .b(OFS), .y(base_d));
  v2c_sat_add #(.W(LLR_W)) u_cand_add (.a(b_llr), .b(base_q), .y(b_adj));

  v2c_flag_store #(.SYM_W(SYM_W)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .wr_en(mark_valid), .wr_bank(wr_bank_q), .wr_sym(mark_sym),
    .clr_en(last_fire), .clr_bank(rd_bank_q),
    .rd_bank(rd_bank_q), .rd_sym(b_sym), .rd_flag(dup)
  );

  v2c_min_select #(.LLR_W(LLR_W), .SYM_W(SYM_W)) u_sel (
    .a_llr(a_llr), .a_sym(a_sym), .b_llr(b_adj), .b_sym(b_sym),
    .pick_a(pick_a), .y_llr(o_llr), .y_sym(o_sym)
  );

  always_comb begin
    merging   = (state_q == ST_MERGE);
    draining  = (state_q == ST_DRAIN);
    o_valid   = merging && a_valid && b_valid && !dup;
    fire      = o_valid && o_ready;
    last_fire = fire && (out_cnt_q == CNT_LAST);
    a_take    = (fire && pick_a) || (draining && a_valid);
    a_ready   = (fire && pick_a) || draining;
    b_ready   = merging && b_valid && (dup || (fire && !pick_a));
    o_last    = (out_cnt_q == CNT_LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      wr_bank_q   <= 1'b0;
      rd_bank_q   <= 1'b0;
      base_q      <= '0;
      out_cnt_q   <= '0;
      a_cnt_q     <= '0;
      prev_llr_q  <= '0;
      have_prev_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (msg_start) begin
          rd_bank_q   <= wr_bank_q;
          wr_bank_q   <= ~wr_bank_q;
          base_q      <= base_d;
          out_cnt_q   <= '0;
          a_cnt_q     <= '0;
          have_prev_q <= 1'b0;
          state_q     <= ST_MERGE;
        end
        ST_MERGE: begin
          if (fire) begin
            out_cnt_q   <= out_cnt_q + CNT_W'(1);
            prev_llr_q  <= o_llr;
            have_prev_q <= 1'b1;
          end
          if (a_take) a_cnt_q <= a_cnt_q + CNT_W'(1);
          if (last_fire)
            state_q <= (a_take && a_cnt_q == CNT_LAST) ? ST_IDLE : ST_DRAIN;
        end
        ST_DRAIN: if (a_valid) begin
          a_cnt_q <= a_cnt_q + CNT_W'(1);
          if (a_cnt_q == CNT_LAST) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R5: outputs never decrease within a message
  p_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && have_prev_q) |-> (o_llr >= prev_llr_q));
  // R5: the output count stays inside the message length while merging
  p_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    merging |-> (out_cnt_q < CNT_W'(NM)));
  // R6: one handshake takes from exactly one source
  p_lazy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (a_ready != b_ready));
  // R4: equal reliabilities favour the corrected stream
  p_tie_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && a_llr == b_adj) |-> a_ready);
  // R7: a stalled output consumes nothing
  p_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && !o_ready) |-> (!a_ready && !b_ready));
  // R8: an accepted start reads the bank just marked and marks the other
  p_pingpong_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && msg_start) |=> (rd_bank_q != wr_bank_q));
  // R10: a start while busy leaves the bank choice alone
  p_busy_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && msg_start) |=> $stable(rd_bank_q));
  // R12: the adjusted candidate never wraps below its operands
  p_sat_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (merging && b_valid) |-> (b_adj >= b_llr && b_adj >= base_q));
endmodule

// File: tb/v2c_merge_bench.sv
module v2c_merge_bench;
  localparam int SW = 6, LW = 8, NM = 12, OFS = 4, Q = 64, NMSG = 48;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, msg_start, mark_valid, a_valid, a_ready, b_valid, b_ready;
  logic          o_valid, o_ready, o_last;
  logic [LW-1:0] tail_llr, a_llr, b_llr, o_llr;
  logic [SW-1:0] mark_sym, a_sym, b_sym, o_sym;

  int checks = 0, errors = 0;
  int al [NM];
  int asy[NM];
  int bl [Q];
  int bsy[Q];
  int exp_l[NM];
  int exp_s[NM];
  int exp_bused;
  bit marked[Q];

  v2c_merge #(.SYM_W(SW), .LLR_W(LW), .NM(NM), .OFFSET(OFS)) u_v2c_merge (
    .clk(clk), .rst_n(rst_n), .msg_start(msg_start), .tail_llr(tail_llr),
    .mark_valid(mark_valid), .mark_sym(mark_sym),
    .a_valid(a_valid), .a_ready(a_ready), .a_llr(a_llr), .a_sym(a_sym),
    .b_valid(b_valid), .b_ready(b_ready), .b_llr(b_llr), .b_sym(b_sym),
    .o_valid(o_valid), .o_ready(o_ready), .o_llr(o_llr), .o_sym(o_sym),
    .o_last(o_last)
  );

  function automatic int sat(input int x);
    return (x > 255) ? 255 : x;
  endfunction
  function automatic int msym(input int k, input int i);
    return (k * 7 + i * 5) % 64;
  endfunction
  function automatic int tail_of(input int k);
    return (k % 8 == 7) ? 250 : (k * 29) % 120;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  // Reference merge built from R2, R3, R4, R12
  task automatic build(input int k);
    int base, ai, bi, n, badj;
    for (int i = 0; i < Q; i++) marked[i] = 1'b0;
    for (int i = 0; i < NM; i++) begin
      al[i]  = sat((k * 37) % 200 + i * (k % 5));
      asy[i] = msym(k, i);
      marked[asy[i]] = 1'b1;
    end
    for (int j = 0; j < Q; j++) begin
      bl[j]  = sat((j * (k % 4)) / 2);
      bsy[j] = (k * 3 + j * 11) % 64;
    end
    base = sat(tail_of(k) + OFS);
    ai = 0; bi = 0; n = 0;
    while (n < NM) begin
      if (marked[bsy[bi]]) bi++;
      else begin
        badj = sat(bl[bi] + base);
        if (al[ai] <= badj) begin exp_l[n] = al[ai]; exp_s[n] = asy[ai]; ai++; end
        else begin exp_l[n] = badj; exp_s[n] = bsy[bi]; bi++; end
        n++;
      end
    end
    exp_bused = bi;
  endtask

  task automatic run_msg(input int k);
    int ai = 0, bi = 0, oi = 0, cyc = 0, mi = 0;
    bit at, bt, ot;
    build(k);
    @(negedge clk);
    msg_start = 1'b1; tail_llr = LW'(tail_of(k));
    mark_valid = 1'b0; a_valid = 1'b0; b_valid = 1'b0; o_ready = 1'b1;
    while ((oi < NM || ai < NM) && cyc < 2000) begin
      @(negedge clk);
      msg_start  = (cyc == 2 && (k % 2) == 1);   // R10: ignored while busy
      tail_llr   = '0;
      a_valid    = (ai < NM);
      a_llr      = LW'(ai < NM ? al[ai] : 0);
      a_sym      = SW'(ai < NM ? asy[ai] : 0);
      b_valid    = (bi < Q);
      b_llr      = LW'(bi < Q ? bl[bi] : 0);
      b_sym      = SW'(bi < Q ? bsy[bi] : 0);
      o_ready    = ((cyc + k) % 3) != 1;
      mark_valid = (k + 1 < NMSG) && (mi < NM);  // R8: next message marked now
      mark_sym   = SW'(msym(k + 1, mi));
      if (mark_valid) mi++;
      #1;
      if (o_valid) begin
        if (oi >= NM) check(1'b0, "R11 extra output", oi, NM - 1);
        else begin
          check(int'(o_llr) == exp_l[oi], "R3/R4 llr", o_llr, exp_l[oi]);
          check(int'(o_sym) == exp_s[oi], "R2/R4 sym", o_sym, exp_s[oi]);
          check(o_last == (oi == NM - 1), "R5 last", o_last, oi == NM - 1);
        end
        if (!o_ready) check(!a_ready && !b_ready, "R7 stall", {a_ready, b_ready}, 0);
      end
      at = a_valid && a_ready; bt = b_valid && b_ready; ot = o_valid && o_ready;
      if (at) ai++;
      if (bt) bi++;
      if (ot) oi++;
      cyc++;
    end
    check(oi == NM, "R5 count", oi, NM);
    check(ai == NM, "R11 drain", ai, NM);
    check(bi == exp_bused, "R6/R2 b consumed", bi, exp_bused);
  endtask

  initial begin
    rst_n = 1'b0; msg_start = 1'b0; tail_llr = '0; mark_valid = 1'b0; mark_sym = '0;
    a_valid = 1'b1; a_llr = '0; a_sym = '0; b_valid = 1'b1; b_llr = '0; b_sym = '0;
    o_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: idle after reset, no handshake even with inputs valid
    check(!o_valid, "R1 o_valid", o_valid, 0);
    check(!a_ready, "R1 a_ready", a_ready, 0);
    check(!b_ready, "R1 b_ready", b_ready, 0);
    @(negedge clk);
    a_valid = 1'b0; b_valid = 1'b0;
    for (int i = 0; i < NM; i++) begin
      mark_valid = 1'b1; mark_sym = SW'(msym(0, i));
      @(negedge clk);
    end
    mark_valid = 1'b0;
    // R9/R12 covered across the sweep: shifted symbol sets, tails near full scale
    for (int k = 0; k < NMSG; k++) run_msg(k);
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule